// File: doc/BRIEF.md
# Split-Bus MSI Snoop Controller

This block keeps coherence state for a small direct-mapped group of line tags that belong to one private cache on a shared snooping bus. The processor presents read and write requests. Each line holds one of the three stable states: Invalid, Shared or Modified. The bus needs a request followed by a grant before a command can go out. For that reason, every processor action that needs the bus first puts the line into a waiting state. The real command is issued only in the cycle the grant arrives. Snooped commands from other caches are checked against the stored tags. They can downgrade a line, or make it answer with a writeback.

The processor holds its request, meaning valid, write flag and address, until `cpu_ready` is high. That cycle is the completion. A hit completes in the same cycle. A miss completes in the cycle its grant is taken. A line whose tag differs from the request is replaced. A dirty victim is written back through its own granted command. After that, the held request starts its own miss in the same cycle. Data storage, arbitration and memory are outside the block.

Top module: `msi_split_snoop`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `bus_cmd_valid` are low, and the first access to any address misses.
- R2: A read to an Invalid line stalls and raises `bus_req` from the next cycle. In the grant cycle it drives command code 0 (read) with the request address and asserts `cpu_ready`, and the line becomes Shared. The address is tag in the upper bits and set index in the lower IDX_W bits.
- R3: A write to an Invalid line does the same with command code 1 (read-exclusive), and the line becomes Modified.
- R4: A write to a Shared line stalls, requests the bus, and on grant drives command code 2 (invalidate) and becomes Modified.
- R5: Reads hitting Shared or Modified, and writes hitting Modified, assert `cpu_ready` in the same cycle with no bus request and no command.
- R6: A snooped read (code 0) matching a Modified line drives command code 3 (writeback) with the snooped address in the same cycle, and leaves the line Shared.
- R7: A snooped read-exclusive matching a Modified line drives a writeback and invalidates the line. A snooped read-exclusive or invalidate matching a Shared line invalidates it with no command.
- R8: A snooped read matching a Shared line leaves it Shared with no command.
- R9: A snooped read-exclusive or invalidate for a line waiting to upgrade from Shared makes its later grant issue read-exclusive instead of invalidate.
- R10: A snooped read-exclusive for a line waiting on a read or write miss causes no command. The request stays up, and the later grant issues the original command.
- R11: While the addressed line waits for the grant, `cpu_ready` stays low and `bus_req` stays high, however many cycles the grant takes.
- R12: A miss to a set holding a Modified line with another tag first requests the bus for a writeback of the victim address (ready low). It then requests again and completes with its own miss command. A Shared victim is dropped silently.
- R13: A snoop whose tag does not match has no effect. A snoop presented while `bus_gnt` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant for this cache |
| bus_cmd_valid | output | 1 | A command is driven this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 writeback |
| bus_cmd_addr | output | TAG_W+IDX_W | Line address of the command |
| snoop_valid | input | 1 | Another cache's command is observed |
| snoop_cmd | input | 2 | Observed command, same coding as `bus_cmd` |
| snoop_addr | input | TAG_W+IDX_W | Line address of the observed command |

## Verification
The hardest cases to reach are the races, where a snooped command lands on a line in the window between its bus request and its grant. The stimulus first parks a line in the waiting state by holding a processor request while the bench arbiter withholds the grant. Only then does it inject the conflicting snoop, and it grants afterwards. The issued command then shows whether the waiting state was changed or kept. Dirty evictions are reached by sweeping every tag through every set, so that each miss lands on a Modified victim.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_M  = 3'd2,
    ST_IS = 3'd3,
    ST_IM = 3'd4,
    ST_SM = 3'd5,
    ST_MI = 3'd6
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_INV = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_t;

  function automatic logic st_waiting(line_st_t s);
    return (s == ST_IS) || (s == ST_IM) || (s == ST_SM) || (s == ST_MI);
  endfunction

endpackage

// File: rtl/msi_bus_stage.sv
module msi_bus_stage
  import msi_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  line_st_t         st_in,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             gnt_sel,
  input  logic             snp_sel,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  output line_st_t         st_out,
  output logic             cmd_v,
  output logic [1:0]       cmd
);

  logic snp_hit;
  logic snp_kill;

  always_comb begin
    snp_hit  = snp_sel && (snp_tag == tag_in);
    snp_kill = (snp_cmd == CMD_RDX) || (snp_cmd == CMD_INV);
    st_out   = st_in;
    cmd_v    = 1'b0;
    cmd      = CMD_RD;
    if (gnt_sel) begin
      unique case (st_in)
        ST_IS: begin cmd_v = 1'b1; cmd = CMD_RD;  st_out = ST_S; end
        ST_IM: begin cmd_v = 1'b1; cmd = CMD_RDX; st_out = ST_M; end
        ST_SM: begin cmd_v = 1'b1; cmd = CMD_INV; st_out = ST_M; end
        ST_MI: begin cmd_v = 1'b1; cmd = CMD_WB;  st_out = ST_I; end
        default: ;
      endcase
    end else if (snp_hit) begin
      unique case (st_in)
        ST_M, ST_MI: begin
          if (snp_cmd == CMD_RD) begin
            cmd_v = 1'b1; cmd = CMD_WB; st_out = ST_S;
          end else if (snp_cmd == CMD_RDX) begin
            cmd_v = 1'b1; cmd = CMD_WB; st_out = ST_I;
          end
        end
        ST_S:  if (snp_kill) st_out = ST_I;
        ST_SM: if (snp_kill) st_out = ST_IM;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/msi_cpu_stage.sv
module msi_cpu_stage
  import msi_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             req_v,
  input  logic             req_wr,
  input  logic [TAG_W-1:0] req_tag,
  input  line_st_t         st_in,
  input  logic [TAG_W-1:0] tag_in,
  output logic             ready,
  output line_st_t         st_out,
  output logic [TAG_W-1:0] tag_out
);

  logic match;

  always_comb begin
    match   = (tag_in == req_tag);
    ready   = 1'b0;
    st_out  = st_in;
    tag_out = tag_in;
    if (req_v && !st_waiting(st_in)) begin
      if (match && st_in == ST_M) begin
        ready = 1'b1;
      end else if (match && st_in == ST_S) begin
        if (req_wr) st_out = ST_SM;
        else        ready  = 1'b1;
      end else if (st_in == ST_M) begin
        st_out = ST_MI;
      end else begin
        tag_out = req_tag;
        st_out  = req_wr ? ST_IM : ST_IS;
      end
    end
  end

endmodule

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_st_t         st_d  [SETS],
  input  logic [TAG_W-1:0] tag_d [SETS],
  output line_st_t         st_q  [SETS],
  output logic [TAG_W-1:0] tag_q [SETS]
);

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic upd;
    assign upd = (st_d[g] != st_q[g]) || (tag_d[g] != tag_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else if (upd) begin
        st_q[g]  <= st_d[g];
        tag_q[g] <= tag_d[g];
      end
    end
  end

endmodule

// File: rtl/msi_split_snoop.sv
module msi_split_snoop
  import msi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [TAG_W+IDX_W-1:0] cpu_addr,
  output logic                   cpu_ready,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic                   bus_cmd_valid,
  output logic [1:0]             bus_cmd,
  output logic [TAG_W+IDX_W-1:0] bus_cmd_addr,
  input  logic                   snoop_valid,
  input  logic [1:0]             snoop_cmd,
  input  logic [TAG_W+IDX_W-1:0] snoop_addr
);

  localparam int SETS = 1 << IDX_W;

  logic rst_meta, rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  line_st_t         st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];
  line_st_t         st1   [SETS];
  line_st_t         st_d  [SETS];
  logic [TAG_W-1:0] tag_d [SETS];
  logic [SETS-1:0]  cmd_v;
  logic [1:0]       cmd_c [SETS];
  logic [SETS-1:0]  wait_vec;

  logic [IDX_W-1:0] cpu_idx, snp_idx, pend_q, pend_d;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic             snp_live;

  assign cpu_idx  = cpu_addr[IDX_W-1:0];
  assign cpu_tag  = cpu_addr[TAG_W+IDX_W-1:IDX_W];
  assign snp_idx  = snoop_addr[IDX_W-1:0];
  assign snp_tag  = snoop_addr[TAG_W+IDX_W-1:IDX_W];
  assign snp_live = snoop_valid && !bus_gnt;

  msi_line_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n_int),
    .st_d  (st_d),
    .tag_d (tag_d),
    .st_q  (st_q),
    .tag_q (tag_q)
  );

  for (genvar g = 0; g < SETS; g++) begin : g_bus
    msi_bus_stage #(.TAG_W(TAG_W)) u_bus (
      .st_in   (st_q[g]),
      .tag_in  (tag_q[g]),
      .gnt_sel (bus_gnt && bus_req && (pend_q == IDX_W'(g))),
      .snp_sel (snp_live && (snp_idx == IDX_W'(g))),
      .snp_cmd (snoop_cmd),
      .snp_tag (snp_tag),
      .st_out  (st1[g]),
      .cmd_v   (cmd_v[g]),
      .cmd     (cmd_c[g])
    );
    assign wait_vec[g] = st_waiting(st_q[g]);
  end

  line_st_t         cpu_st;
  logic [TAG_W-1:0] cpu_tag_nx;

  msi_cpu_stage #(.TAG_W(TAG_W)) u_cpu (
    .req_v   (cpu_valid),
    .req_wr  (cpu_write),
    .req_tag (cpu_tag),
    .st_in   (st1[cpu_idx]),
    .tag_in  (tag_q[cpu_idx]),
    .ready   (cpu_ready),
    .st_out  (cpu_st),
    .tag_out (cpu_tag_nx)
  );

  always_comb begin
    for (int i = 0; i < SETS; i++) begin
      if (IDX_W'(i) == cpu_idx) begin
        st_d[i]  = cpu_st;
        tag_d[i] = cpu_tag_nx;
      end else begin
        st_d[i]  = st1[i];
        tag_d[i] = tag_q[i];
      end
    end
  end

  always_comb begin
    bus_cmd_valid = 1'b0;
    bus_cmd       = CMD_RD;
    bus_cmd_addr  = '0;
    for (int i = 0; i < SETS; i++) begin
      if (cmd_v[i]) begin
        bus_cmd_valid = 1'b1;
        bus_cmd       = cmd_c[i];
        bus_cmd_addr  = {tag_q[i], IDX_W'(i)};
      end
    end
  end

  assign pend_d  = (cpu_valid && st_waiting(cpu_st)) ? cpu_idx : pend_q;
  assign bus_req = st_waiting(st_q[pend_q]);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) pend_q <= '0;
    else if (pend_d != pend_q) pend_q <= pend_d;
  end

  // a grant taken while requesting always carries a command
  assert_gnt_issues_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_gnt && bus_req) |-> bus_cmd_valid);

  // without a grant the only possible command is a snoop writeback
  assert_snoop_only_wb_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_cmd_valid && !bus_gnt) |-> (bus_cmd == CMD_WB));

  // quiet bus cycles drive nothing
  assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!bus_gnt && !snoop_valid) |-> !bus_cmd_valid);

  // a pending request is held until granted
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_req && !bus_gnt && !snoop_valid) |=> bus_req);

  // the processor never completes on a waiting line before its grant
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_valid && wait_vec[cpu_idx] && !bus_gnt && !snoop_valid) |-> !cpu_ready);

  // one held request leaves at most one line waiting
  assert_single_wait_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones(wait_vec) <= 1);

endmodule

// File: tb/sim_msi_split_snoop.sv
module sim_msi_split_snoop;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 2;
  localparam int TAG_W = 2;
  localparam int AW = IDX_W + TAG_W;
  localparam int SETS = 1 << IDX_W;
  localparam int NTAG = 1 << TAG_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_valid, cpu_write;
  logic [AW-1:0] cpu_addr;
  logic          cpu_ready, bus_req, bus_gnt, bus_cmd_valid;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_cmd_addr;
  logic          snoop_valid;
  logic [1:0]    snoop_cmd;
  logic [AW-1:0] snoop_addr;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_split_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_cmd_addr(bus_cmd_addr),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle();
    cpu_valid = 1'b0; cpu_write = 1'b0; bus_gnt = 1'b0; snoop_valid = 1'b0;
  endtask

  // miss: request, wait, grant, expect command and completion in grant cycle
  task automatic miss(input int a, input bit wr, input int exp_cmd, input int waits, input string rq);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = AW'(a); #1;
    chk({rq, " miss ready"}, cpu_ready, 0);
    chk({rq, " miss no cmd"}, bus_cmd_valid, 0);
    for (int w = 0; w <= waits; w++) begin
      @(negedge clk); #1;
      chk({rq, " R11 req held"}, bus_req, 1);
      chk({rq, " R11 stall"}, cpu_ready, 0);
    end
    bus_gnt = 1'b1; #1;
    chk({rq, " grant cmd valid"}, bus_cmd_valid, 1);
    chk({rq, " grant cmd"}, bus_cmd, exp_cmd);
    chk({rq, " grant addr"}, bus_cmd_addr, a);
    chk({rq, " grant ready"}, cpu_ready, 1);
    @(posedge clk); #1; idle();
  endtask

  task automatic hit(input int a, input bit wr, input string rq);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = AW'(a); #1;
    chk({rq, " hit ready"}, cpu_ready, 1);
    chk({rq, " hit no cmd"}, bus_cmd_valid, 0);
    chk({rq, " hit no req"}, bus_req, 0);
    @(posedge clk); #1; idle();
  endtask

  task automatic snoop(input int a, input int c, input bit exp_wb, input string rq);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = 2'(c); snoop_addr = AW'(a); #1;
    chk({rq, " snoop cmd valid"}, bus_cmd_valid, exp_wb);
    if (exp_wb) begin
      chk({rq, " snoop wb code"}, bus_cmd, 3);
      chk({rq, " snoop wb addr"}, bus_cmd_addr, a);
    end
    @(posedge clk); #1; idle();
  endtask

  // dirty eviction: writeback of victim, then own miss command
  task automatic evict(input int a, input bit wr, input int victim, input int exp_cmd);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = AW'(a); #1;
    chk("R12 ready low", cpu_ready, 0);
    @(negedge clk); #1;
    chk("R12 evict req", bus_req, 1);
    bus_gnt = 1'b1; #1;
    chk("R12 wb valid", bus_cmd_valid, 1);
    chk("R12 wb code", bus_cmd, 3);
    chk("R12 wb victim addr", bus_cmd_addr, victim);
    chk("R12 ready low in wb", cpu_ready, 0);
    @(posedge clk); #1; bus_gnt = 1'b0;
    @(negedge clk); #1;
    chk("R12 second req", bus_req, 1);
    bus_gnt = 1'b1; #1;
    chk("R12 miss cmd", bus_cmd, exp_cmd);
    chk("R12 miss addr", bus_cmd_addr, a);
    chk("R12 ready", cpu_ready, 1);
    @(posedge clk); #1; idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); cpu_addr = '0; snoop_cmd = '0; snoop_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset req", bus_req, 0);
    chk("R1 reset cmd", bus_cmd_valid, 0);
    chk("R1 reset ready", cpu_ready, 0);

    // sweep every set and tag
    for (int s = 0; s < SETS; s++) begin
      for (int t = 0; t < NTAG; t++) begin
        int a  = t * SETS + s;
        int a2 = ((t + 1) % NTAG) * SETS + s;
        miss(a, 1'b0, 0, t, "R1 R2 read miss");
        hit(a, 1'b0, "R5 read S");
        snoop(a, 0, 1'b0, "R8 rd on S");
        miss(a, 1'b1, 2, t, "R4 upgrade");
        hit(a, 1'b1, "R5 write M");
        hit(a, 1'b0, "R5 read M");
        snoop(a, 0, 1'b1, "R6 rd on M");
        snoop(a, 1, 1'b0, "R7 rdx on S");
        miss(a, 1'b1, 1, 0, "R3 write miss");
        snoop(a, 1, 1'b1, "R7 rdx on M");
        miss(a, 1'b1, 1, 1, "R3 write miss again");
        evict(a2, 1'b0, a, 0);
        miss(a, 1'b0, 0, 0, "R12 silent S victim");
        snoop(a, 2, 1'b0, "R7 inv on S");
      end
    end

    // R9: upgrade raced by invalidate, then by read-exclusive
    for (int k = 0; k < 2; k++) begin
      miss(5, 1'b0, 0, 0, "R9 setup");
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = AW'(5); #1;
      chk("R9 ready low", cpu_ready, 0);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = (k == 0) ? 2'd2 : 2'd1; snoop_addr = AW'(5); #1;
      chk("R9 no cmd on snoop", bus_cmd_valid, 0);
      @(posedge clk); #1; snoop_valid = 1'b0;
      @(negedge clk); #1;
      chk("R9 req", bus_req, 1);
      bus_gnt = 1'b1; #1;
      chk("R9 rdx instead of inv", bus_cmd, 1);
      chk("R9 ready", cpu_ready, 1);
      @(posedge clk); #1; idle();
      hit(5, 1'b1, "R9 now M");
      snoop(5, 1, 1'b1, "R9 cleanup");
    end

    // R10: read miss and write miss raced by read-exclusive
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = k[0]; cpu_addr = AW'(6); #1;
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = 2'd1; snoop_addr = AW'(6); #1;
      chk("R10 no cmd", bus_cmd_valid, 0);
      chk("R10 ready low", cpu_ready, 0);
      @(posedge clk); #1; snoop_valid = 1'b0;
      @(negedge clk); #1;
      chk("R10 req kept", bus_req, 1);
      bus_gnt = 1'b1; #1;
      chk("R10 original cmd", bus_cmd, k);
      chk("R10 ready", cpu_ready, 1);
      @(posedge clk); #1; idle();
      hit(6, 1'b0, "R10 line usable");
      snoop(6, 1, k[0], "R10 cleanup");
    end

    // R13: mismatching tag snoop, and snoop during grant
    miss(3, 1'b1, 1, 0, "R13 setup");
    snoop(3 + SETS, 0, 1'b0, "R13 tag mismatch");
    hit(3, 1'b1, "R13 still M");
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = AW'(1); #1;
    @(negedge clk); #1;
    bus_gnt = 1'b1; snoop_valid = 1'b1; snoop_cmd = 2'd0; snoop_addr = AW'(3); #1;
    chk("R13 grant cmd wins", bus_cmd, 0);
    chk("R13 grant addr", bus_cmd_addr, 1);
    @(posedge clk); #1; idle();
    hit(3, 1'b1, "R13 snoop ignored in grant");

    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule